// File: doc/BRIEF.md
# Glitch-Free Clock Stop and Power-Down Controller

This block sits between a set of already-generated clocks and the pins that carry them. It gates each clock class in response to three asynchronous active-low requests: a processor-clock stop, a PCI-clock stop and a power-down. A gated clock is never cut mid-pulse. Its enable register only moves while the incoming clock is low, so every high pulse that leaves the block is exactly as wide as the incoming one. When a clock is stopped, its output rests at a static low.

All logic runs on one base clock `clk`, which is fast enough to sample every gated clock as data. Each output is the input clock gated and delayed by one base cycle. The stop requests are synchronised into `clk` and then taken only on a rising edge of the free-running PCI input. Latency is therefore counted in PCI edges.

On power-down the block stops all clocks and then lowers the oscillator and VCO enables. When power-down is released, it raises those enables again but keeps every clock held low for a parameterised stabilisation wait before the clocks restart. Reset enters that same wait.

Top module: `ckg_stop_ctrl`

## Requirements
- R1: While `osc_en_o` has been low for two consecutive base cycles, every clock output is low. `osc_en_o` and `vco_en_o` are low only while powered down.
- R2: With `cpu_stop_n` low, `cpu_o` and `mid_o` hold low. `half_o`, `apic_o`, `ref_o`, `usb_o` and `pci_free_o` keep toggling.
- R3: With `pci_stop_n` low, `pci_o` holds low. `pci_free_o` and the processor group keep toggling.
- R4: Each output high pulse lasts exactly as long as the matching input high phase and starts one base cycle later. The only exception is the forced cut when the oscillator turns off.
- R5: A change on `cpu_stop_n` or `pci_stop_n` takes effect at the first PCI input rising edge after `SYNC_STAGES` base cycles. The group is then stopped or restarted by the end of its next low phase.
- R6: With `pwrdn_n` low after synchronisation, the first PCI rising edge stops every clock group. The second PCI rising edge lowers `osc_en_o` and `vco_en_o`.
- R7: After `pwrdn_n` returns high and is synchronised, the oscillator and VCO enables rise at once. All outputs stay low for `WAKE_CYCLES` base cycles, and then the enabled groups restart.
- R8: After reset, all outputs are low, `osc_en_o` and `vco_en_o` are high, and the clocks start only after the R7 wait.
- R9: With both stop requests low, the processor group and the PCI group are low while the free-running group keeps toggling. A power-down cycle in this state leaves both groups stopped after wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_stop_n | input | 1 | Async request to stop processor and 66-class clocks (low) |
| pci_stop_n | input | 1 | Async request to stop gated PCI clocks (low) |
| pwrdn_n | input | 1 | Async power-down request (low) |
| clk_cpu_i | input | 1 | Processor clock to gate |
| clk_mid_i | input | 1 | 66-class clock to gate |
| clk_half_i | input | 1 | Half-rate memory reference clock |
| clk_pci_i | input | 1 | PCI clock, also the latency reference |
| clk_apic_i | input | 1 | Interrupt-controller clock |
| clk_ref_i | input | 1 | Crystal reference copy |
| clk_usb_i | input | 1 | 48 MHz class clock |
| cpu_o | output | N_CPU | Gated processor clocks |
| mid_o | output | N_MID | Gated 66-class clocks |
| half_o | output | N_HALF | Memory reference clocks |
| pci_free_o | output | 1 | Free-running PCI clock |
| pci_o | output | N_PCI | Stoppable PCI clocks |
| apic_o | output | N_APIC | Interrupt-controller clocks |
| ref_o | output | N_REF | Reference clocks |
| usb_o | output | 1 | 48 MHz class clock |
| osc_en_o | output | 1 | Oscillator enable |
| vco_en_o | output | 1 | VCO enable |

## Verification
The hardest state to reach is the edge of power-down while a stop request is also held. There, the stabilisation wait, the PCI-edge sampling and the per-clock low-phase gating all interact.

The stimulus holds `cpu_stop_n` low and runs a full power-down and wake cycle. It checks that the processor group stays silent after the wait while the other groups return.

Each stimulus step waits for a PCI input rising edge before the window is observed, so R5 latency is exercised at the port. A pulse-width monitor runs the whole time to catch any runt pulse produced across enable changes.

// File: rtl/ckg_pkg.sv
package ckg_pkg;
   typedef enum logic [1:0] {
      PW_WAKE  = 2'd0,
      PW_RUN   = 2'd1,
      PW_DRAIN = 2'd2,
      PW_DOWN  = 2'd3
   } pw_state_e;
endpackage

// File: rtl/ckg_sync.sv
module ckg_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("ckg_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("ckg_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
      end else begin
         stg[0] <= din;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/ckg_gate.sv
module ckg_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic clk_in,
   input  logic req,
   input  logic kill,
   output logic clk_out
);
   logic en_q;
   logic out_q;

   // the enable may only move while the incoming clock is low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         out_q <= 1'b0;
      end else begin
         if (!clk_in) en_q <= req & ~kill;
         out_q <= clk_in & en_q & ~kill;
      end
   end

   assign clk_out = out_q;

   // R4
   out_follows_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_q |-> $past(clk_in));

   // R4
   no_runt_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_q) |-> (!$past(clk_in) || $past(kill)));
endmodule

// File: rtl/ckg_pwr_fsm.sv
module ckg_pwr_fsm
   import ckg_pkg::*;
#(
   parameter int WAKE_CYCLES = 300000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pd_n_s,
   input  logic pci_rise,
   output logic run,
   output logic kill,
   output logic osc_en,
   output logic vco_en
);
   localparam int CW = $clog2(WAKE_CYCLES + 1);
   localparam logic [CW-1:0] CNT_LAST = CW'(WAKE_CYCLES - 1);

   generate
      if (WAKE_CYCLES < 1) begin : g_bad_wake
         $error("ckg_pwr_fsm: WAKE_CYCLES must be at least 1");
      end
   endgenerate

   pw_state_e state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         PW_WAKE: begin
            if (!pd_n_s) begin
               state_d = PW_DOWN;
            end else if (cnt_q == CNT_LAST) begin
               state_d = PW_RUN;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         PW_RUN:   if (!pd_n_s && pci_rise) state_d = PW_DRAIN;
         PW_DRAIN: if (pci_rise) state_d = PW_DOWN;
         PW_DOWN: begin
            if (pd_n_s) begin
               state_d = PW_WAKE;
               cnt_d   = '0;
            end
         end
         default: state_d = PW_WAKE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PW_WAKE;
         cnt_q   <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
      end
   end

   assign run    = (state_q == PW_RUN);
   assign kill   = (state_q == PW_DOWN);
   assign osc_en = ~kill;
   assign vco_en = ~kill;

   // R6
   drain_to_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == PW_DRAIN && pci_rise) |=> !osc_en);

   // R7
   wake_wait_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run) |-> ($past(cnt_q) == CNT_LAST));
endmodule

// File: rtl/ckg_stop_ctrl.sv
module ckg_stop_ctrl #(
   parameter int N_CPU       = 4,
   parameter int N_MID       = 4,
   parameter int N_HALF      = 2,
   parameter int N_PCI       = 7,
   parameter int N_APIC      = 3,
   parameter int N_REF       = 2,
   parameter int SYNC_STAGES = 2,
   parameter int WAKE_CYCLES = 300000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_stop_n,
   input  logic              pci_stop_n,
   input  logic              pwrdn_n,
   input  logic              clk_cpu_i,
   input  logic              clk_mid_i,
   input  logic              clk_half_i,
   input  logic              clk_pci_i,
   input  logic              clk_apic_i,
   input  logic              clk_ref_i,
   input  logic              clk_usb_i,
   output logic [N_CPU-1:0]  cpu_o,
   output logic [N_MID-1:0]  mid_o,
   output logic [N_HALF-1:0] half_o,
   output logic              pci_free_o,
   output logic [N_PCI-1:0]  pci_o,
   output logic [N_APIC-1:0] apic_o,
   output logic [N_REF-1:0]  ref_o,
   output logic              usb_o,
   output logic              osc_en_o,
   output logic              vco_en_o
);
   generate
      if (N_CPU < 1 || N_MID < 1 || N_HALF < 1 || N_PCI < 1 || N_APIC < 1 || N_REF < 1) begin : g_bad_counts
         $error("ckg_stop_ctrl: every output group needs at least one copy");
      end
   endgenerate

   logic [2:0] ctl_s;
   logic       cpu_s, pci_s, pd_s;
   logic       pci_q, pci_rise;
   logic       cpu_req, pci_req;
   logic       run, kill;
   logic       cpu_grp_req, pci_grp_req;

   ckg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({pwrdn_n, pci_stop_n, cpu_stop_n}),
      .dout (ctl_s)
   );
   assign {pd_s, pci_s, cpu_s} = ctl_s;

   // stop requests are taken on rising edges of the free-running PCI clock
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pci_q   <= 1'b0;
         cpu_req <= 1'b1;
         pci_req <= 1'b1;
      end else begin
         pci_q <= clk_pci_i;
         if (pci_rise) begin
            cpu_req <= cpu_s;
            pci_req <= pci_s;
         end
      end
   end
   assign pci_rise = clk_pci_i & ~pci_q;

   ckg_pwr_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_pwr (
      .clk     (clk),
      .rst_n   (rst_n),
      .pd_n_s  (pd_s),
      .pci_rise(pci_rise),
      .run     (run),
      .kill    (kill),
      .osc_en  (osc_en_o),
      .vco_en  (vco_en_o)
   );

   assign cpu_grp_req = run & cpu_req;
   assign pci_grp_req = run & pci_req;

   genvar gi;
   generate
      for (gi = 0; gi < N_CPU; gi++) begin : g_cpu
         ckg_gate u_g (.clk(clk), .rst_n(rst_n), .clk_in(clk_cpu_i),
                       .req(cpu_grp_req), .kill(kill), .clk_out(cpu_o[gi]));
      end
      for (gi = 0; gi < N_MID; gi++) begin : g_mid
         ckg_gate u_g (.clk(clk), .rst_n(rst_n), .clk_in(clk_mid_i),
                       .req(cpu_grp_req), .kill(kill), .clk_out(mid_o[gi]));
      end
      for (gi = 0; gi < N_HALF; gi++) begin : g_half
         ckg_gate u_g (.clk(clk), .rst_n(rst_n), .clk_in(clk_half_i),
                       .req(run), .kill(kill), .clk_out(half_o[gi]));
      end
      for (gi = 0; gi < N_PCI; gi++) begin : g_pci
         ckg_gate u_g (.clk(clk), .rst_n(rst_n), .clk_in(clk_pci_i),
                       .req(pci_grp_req), .kill(kill), .clk_out(pci_o[gi]));
      end
      for (gi = 0; gi < N_APIC; gi++) begin : g_apic
         ckg_gate u_g (.clk(clk), .rst_n(rst_n), .clk_in(clk_apic_i),
                       .req(run), .kill(kill), .clk_out(apic_o[gi]));
      end
      for (gi = 0; gi < N_REF; gi++) begin : g_ref
         ckg_gate u_g (.clk(clk), .rst_n(rst_n), .clk_in(clk_ref_i),
                       .req(run), .kill(kill), .clk_out(ref_o[gi]));
      end
   endgenerate

   ckg_gate u_pci_free (.clk(clk), .rst_n(rst_n), .clk_in(clk_pci_i),
                        .req(run), .kill(kill), .clk_out(pci_free_o));
   ckg_gate u_usb (.clk(clk), .rst_n(rst_n), .clk_in(clk_usb_i),
                   .req(run), .kill(kill), .clk_out(usb_o));

   // R1
   off_means_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!osc_en_o && $past(!osc_en_o)) |->
         (cpu_o == '0 && mid_o == '0 && half_o == '0 && pci_o == '0 &&
          apic_o == '0 && ref_o == '0 && !pci_free_o && !usb_o));

   // R2
   cpu_stop_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_req && !clk_cpu_i) |=> ##1 (cpu_o == '0));
endmodule

// File: tb/sim_ckg_stop_ctrl.sv
module sim_ckg_stop_ctrl;
   localparam int SYNC = 2;
   localparam int WAKE = 100;
   localparam int WIN  = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwrdn_n = 1'b1;
   logic [3:0] div = '0;
   logic [3:0]  cpu_o, mid_o, pci_unused;
   logic [1:0]  half_o, ref_o;
   logic [6:0]  pci_o;
   logic [2:0]  apic_o;
   logic        pci_free_o, usb_o, osc_en_o, vco_en_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;
   bit mon_busy = 1'b0;

   always #2 clk = ~clk;
   always @(negedge clk) div <= div + 1'b1;

   ckg_stop_ctrl #(.SYNC_STAGES(SYNC), .WAKE_CYCLES(WAKE)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
      .clk_cpu_i(div[0]), .clk_mid_i(div[1]), .clk_half_i(div[1]),
      .clk_pci_i(div[2]), .clk_apic_i(div[3]), .clk_ref_i(div[1]),
      .clk_usb_i(div[0]),
      .cpu_o(cpu_o), .mid_o(mid_o), .half_o(half_o), .pci_free_o(pci_free_o),
      .pci_o(pci_o), .apic_o(apic_o), .ref_o(ref_o), .usb_o(usb_o),
      .osc_en_o(osc_en_o), .vco_en_o(vco_en_o)
   );
   assign pci_unused = '0;

   typedef struct {
      bit cpu_on;
      bit pci_on;
      bit free_on;
      bit osc;
      string tag;
   } exp_t;
   exp_t sb[$];

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic expect_state(input bit c, input bit p, input bit f, input bit o, input string tag);
      exp_t e;
      e.cpu_on = c; e.pci_on = p; e.free_on = f; e.osc = o; e.tag = tag;
      sb.push_back(e);
      #1;
      wait (!mon_busy && sb.size() == 0);
   endtask

   task automatic settle();
      repeat (SYNC + 1) @(posedge clk);
      @(posedge div[2]);
      repeat (20) @(posedge clk);
   endtask

   // scoreboard monitor: observes one window per expected item
   initial begin
      exp_t e;
      int rc, rm, rp, rf, rh, ra, rr, ru;
      bit osc_ok;
      logic [7:0] prev;
      forever begin
         wait (sb.size() > 0);
         mon_busy = 1'b1;
         e = sb.pop_front();
         rc = 0; rm = 0; rp = 0; rf = 0; rh = 0; ra = 0; rr = 0; ru = 0;
         osc_ok = 1'b1;
         prev = '0;
         for (int i = 0; i < WIN; i++) begin
            @(posedge clk); #1;
            if (cpu_o[0] && !prev[0]) rc++;
            if (mid_o[0] && !prev[1]) rm++;
            if (pci_o[0] && !prev[2]) rp++;
            if (pci_free_o && !prev[3]) rf++;
            if (half_o[0] && !prev[4]) rh++;
            if (apic_o[0] && !prev[5]) ra++;
            if (ref_o[0] && !prev[6]) rr++;
            if (usb_o && !prev[7]) ru++;
            prev = {usb_o, ref_o[0], apic_o[0], half_o[0], pci_free_o, pci_o[0], mid_o[0], cpu_o[0]};
            if (osc_en_o !== e.osc || vco_en_o !== e.osc) osc_ok = 1'b0;
            if (!e.cpu_on && (cpu_o != '0 || mid_o != '0)) rc += 1000;
            if (!e.pci_on && pci_o != '0) rp += 1000;
         end
         if (e.cpu_on) check(rc > 0 && rc < 1000 && rm > 0, {e.tag, " cpu group running"}, rc, 1);
         else          check(rc == 0 && rm == 0, {e.tag, " cpu group held low"}, rc + rm, 0);
         if (e.pci_on) check(rp > 0 && rp < 1000, {e.tag, " pci group running"}, rp, 1);
         else          check(rp == 0, {e.tag, " pci group held low"}, rp, 0);
         if (e.free_on) check(rf > 0 && rh > 0 && ra > 0 && rr > 0 && ru > 0,
                              {e.tag, " free group running"}, rf * ra, 1);
         else           check(rf + rh + ra + rr + ru == 0, {e.tag, " free group held low"},
                              rf + rh + ra + rr + ru, 0);
         check(osc_ok, {e.tag, " osc/vco enables"}, osc_en_o, e.osc);
         mon_busy = 1'b0;
      end
   end

   // R4: pulse widths of gated outputs match the input high phases
   initial begin
      int wc, wp, wa;
      wc = 0; wp = 0; wa = 0;
      forever begin
         @(posedge clk); #1;
         if (cpu_o[0]) wc++;
         else begin
            if (wc != 0 && osc_en_o) check(wc == 1, "R4 cpu pulse width", wc, 1);
            wc = 0;
         end
         if (pci_o[0]) wp++;
         else begin
            if (wp != 0 && osc_en_o) check(wp == 4, "R4 pci pulse width", wp, 4);
            wp = 0;
         end
         if (apic_o[0]) wa++;
         else begin
            if (wa != 0 && osc_en_o) check(wa == 8, "R4 apic pulse width", wa, 8);
            wa = 0;
         end
      end
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      // R8: held low during the wake wait, enables up
      expect_state(0, 0, 0, 1, "R8 after reset");
      repeat (WAKE) @(posedge clk);
      expect_state(1, 1, 1, 1, "R8 running");

      cpu_stop_n = 1'b0; settle();
      expect_state(0, 1, 1, 1, "R2 cpu stop");

      cpu_stop_n = 1'b1; pci_stop_n = 1'b0; settle();
      expect_state(1, 0, 1, 1, "R3 pci stop, R5 cpu restart");

      cpu_stop_n = 1'b0; settle();
      expect_state(0, 0, 1, 1, "R9 both stopped");

      cpu_stop_n = 1'b1; pci_stop_n = 1'b1; settle();
      expect_state(1, 1, 1, 1, "R5 both restarted");

      // R6 / R1: power-down entry within two PCI edges
      pwrdn_n = 1'b0;
      repeat (SYNC + 1) @(posedge clk);
      @(posedge div[2]); @(posedge div[2]);
      repeat (3) @(posedge clk);
      expect_state(0, 0, 0, 0, "R6 R1 powered down");

      // R7: wake wait then restart
      pwrdn_n = 1'b1;
      repeat (SYNC + 3) @(posedge clk);
      expect_state(0, 0, 0, 1, "R7 wake wait");
      repeat (60) @(posedge clk);
      expect_state(1, 1, 1, 1, "R7 restarted");

      // R9: power-down cycle while cpu stop held
      cpu_stop_n = 1'b0; settle();
      pwrdn_n = 1'b0;
      repeat (SYNC + 30) @(posedge clk);
      expect_state(0, 0, 0, 0, "R9 R1 down with cpu stop");
      pwrdn_n = 1'b1;
      repeat (WAKE + 40) @(posedge clk);
      expect_state(0, 1, 1, 1, "R9 wake keeps cpu stopped");

      cpu_stop_n = 1'b1; settle();
      expect_state(1, 1, 1, 1, "R5 cpu restart after wake");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule